// File: doc/BRIEF.md
# Debug Event Response Arbiter

This block decides what a processor core does with each debug event that arrives while the core is running normally. A core can also be in Debug state, the halted condition in which a debugger examines it. The block looks at a global debug enable, a flag saying whether the core's current state permits debugging, a 2-bit debug-mode select and a privileged-mode flag. It sorts every incoming event into one of four outcomes: enter Debug state, raise a Debug exception, raise a Prefetch Abort, or ignore the event.

The events come from six sources: an external debug request, a halt command from the test access port, a breakpoint instruction, a register breakpoint hit, a watchpoint hit and a vector catch. Breakpoint hits and vector catches carry a small type tag. The block filters these by mode, arbitrates between events that arrive in the same cycle, and emits at most one one-cycle action pulse. It keeps a sticky Debug-state flag and a 4-bit record of the cause of the last entry. The flag stays set until the surrounding logic clears it with a synchronous clear input.

Top module: `dbg_event_arbiter`

## Requirements
- R1: While `dbg_en_i` is 0, no source causes Debug state entry or a Debug exception, and a breakpoint instruction yields a Prefetch Abort pulse.
- R2: With debug enabled and permitted, an external request enters Debug state under every mode value, including 00, and loads method code 0100.
- R3: With debug enabled and permitted, a halt command enters Debug state under every mode value and loads method code 0000, overwriting any earlier code.
- R4: Mode values 01 and 11 select Halting. With debug enabled and permitted, every software event enters Debug state. The method codes are 0001 for a breakpoint hit, 0010 for a watchpoint, 0011 for a breakpoint instruction and 0101 for a vector catch.
- R5: Mode value 10 selects Monitor. With debug enabled and permitted, a software event pulses `dbg_exc_o` and leaves the Debug-state flag and the method code unchanged.
- R6: In Monitor mode, vector catches tagged 011 (prefetch abort vector) or 100 (data abort vector) are ignored.
- R7: In Monitor mode with `priv_i` = 1, breakpoint hits tagged 10 (unlinked context ID) or 11 (address mismatch) are ignored. The same hits raise a Debug exception when `priv_i` = 0, and a hit tagged 01 raises one in either privilege.
- R8: With mode 00, or with `dbg_permit_i` = 0, breakpoint hits, watchpoints and vector catches are ignored, and a breakpoint instruction yields a Prefetch Abort pulse.
- R9: When several events arrive in one cycle, the order is external request, halt command, breakpoint instruction, breakpoint hit, watchpoint, vector catch. Events the filters ignore fall out of this order. At most one action pulse is produced per cycle.
- R10: The action pulses and the Debug-state flag change on the clock edge that samples the event. While the flag is set, every event is ignored. `state_clr_i` drops the flag at the next edge.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en_i | input | 1 | Global debug enable |
| dbg_permit_i | input | 1 | Core state permits debug |
| dbg_mode_i | input | 2 | Mode select: 00 none, 01/11 Halting, 10 Monitor |
| priv_i | input | 1 | Core is in a privileged mode |
| ext_req_i | input | 1 | External debug request strobe |
| halt_cmd_i | input | 1 | Halt command from test access port |
| bkpt_insn_i | input | 1 | Breakpoint instruction strobe |
| brk_hit_i | input | 1 | Register breakpoint hit strobe |
| brk_kind_i | input | 2 | Breakpoint tag: 00 address, 01 linked context, 10 unlinked context ID, 11 address mismatch |
| wpt_hit_i | input | 1 | Watchpoint hit strobe |
| vcatch_hit_i | input | 1 | Vector catch strobe |
| vcatch_kind_i | input | 3 | Vector tag: 011 prefetch abort, 100 data abort, others generic |
| state_clr_i | input | 1 | Synchronous clear of the Debug-state flag |
| enter_o | output | 1 | One-cycle Debug state entry pulse |
| dbg_exc_o | output | 1 | One-cycle Debug exception pulse |
| pabort_o | output | 1 | One-cycle Prefetch Abort pulse |
| in_debug_o | output | 1 | Sticky Debug-state flag |
| entry_method_o | output | 4 | Cause of last entry |

## Verification
Each event source is tried on its own under every mode value with enable and permit both high. This separates Halting from Monitor from no-mode handling, and shows the method code for each source. The same sources are then tried with enable low and with permit low, which shows that only the breakpoint instruction still yields an action (a Prefetch Abort). Type tags are swept in Monitor mode in both privilege levels to isolate each suppression rule. Combined strobes show the order of priority and show that a filtered event yields to the next one. Events presented while the flag is set, and on the clear cycle, show the sticky blocking.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
  localparam int MOE_W   = 4;
  localparam int MODE_W  = 2;
  localparam int BK_W    = 2;
  localparam int VK_W    = 3;
  localparam int NUM_SRC = 6;
  localparam int SRC_W   = $clog2(NUM_SRC);

  // source index doubles as priority: lower index wins
  localparam int SRC_EXT  = 0;
  localparam int SRC_HALT = 1;
  localparam int SRC_BKI  = 2;
  localparam int SRC_BRK  = 3;
  localparam int SRC_WPT  = 4;
  localparam int SRC_VC   = 5;

  typedef enum logic [1:0] {ACT_NONE, ACT_ENTER, ACT_EXC, ACT_PABT} act_t;

  localparam logic [MOE_W-1:0] MOE_HALT = 4'b0000;
  localparam logic [MOE_W-1:0] MOE_BRK  = 4'b0001;
  localparam logic [MOE_W-1:0] MOE_WPT  = 4'b0010;
  localparam logic [MOE_W-1:0] MOE_BKI  = 4'b0011;
  localparam logic [MOE_W-1:0] MOE_EXT  = 4'b0100;
  localparam logic [MOE_W-1:0] MOE_VC   = 4'b0101;

  localparam logic [BK_W-1:0] BK_UNLINKED_CID = 2'b10;
  localparam logic [BK_W-1:0] BK_MISMATCH     = 2'b11;
  localparam logic [VK_W-1:0] VK_PABT         = 3'b011;
  localparam logic [VK_W-1:0] VK_DABT         = 3'b100;

  function automatic logic is_halting(input logic [MODE_W-1:0] m);
    return m[0];
  endfunction

  function automatic logic is_monitor(input logic [MODE_W-1:0] m);
    return (m == 2'b10);
  endfunction

  // Monitor-mode suppression of a software source
  function automatic logic mon_drop(input int src, input logic priv,
                                    input logic [BK_W-1:0] bk,
                                    input logic [VK_W-1:0] vk);
    logic drop;
    drop = 1'b0;
    if (src == SRC_VC)
      drop = (vk == VK_PABT) || (vk == VK_DABT);
    else if (src == SRC_BRK)
      drop = priv && ((bk == BK_UNLINKED_CID) || (bk == BK_MISMATCH));
    return drop;
  endfunction

  function automatic act_t src_action(input int src, input logic en_ok,
                                      input logic [MODE_W-1:0] m, input logic priv,
                                      input logic [BK_W-1:0] bk,
                                      input logic [VK_W-1:0] vk);
    act_t a;
    a = ACT_NONE;
    if (src == SRC_EXT || src == SRC_HALT) begin
      if (en_ok) a = ACT_ENTER;
    end else if (en_ok && is_halting(m)) begin
      a = ACT_ENTER;
    end else if (en_ok && is_monitor(m)) begin
      if (!mon_drop(src, priv, bk, vk)) a = ACT_EXC;
    end else if (src == SRC_BKI) begin
      a = ACT_PABT;
    end
    return a;
  endfunction

  function automatic logic [MOE_W-1:0] src_moe(input int src);
    logic [MOE_W-1:0] c;
    case (src)
      SRC_EXT: c = MOE_EXT;
      SRC_BKI: c = MOE_BKI;
      SRC_BRK: c = MOE_BRK;
      SRC_WPT: c = MOE_WPT;
      SRC_VC:  c = MOE_VC;
      default: c = MOE_HALT;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/dbg_evt_filter.sv
module dbg_evt_filter
  import dbg_arb_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]      ev_i,
  input  logic              blocked_i,
  input  logic              en_ok_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              priv_i,
  input  logic [BK_W-1:0]   bk_i,
  input  logic [VK_W-1:0]   vk_i,
  output act_t [N-1:0]      act_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    always_comb begin
      if (ev_i[g] && !blocked_i)
        act_o[g] = src_action(g, en_ok_i, mode_i, priv_i, bk_i, vk_i);
      else
        act_o[g] = ACT_NONE;
    end
  end
endmodule

// File: rtl/dbg_evt_prio.sv
module dbg_evt_prio
  import dbg_arb_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  act_t [N-1:0]     act_i,
  output act_t             win_act_o,
  output logic [MOE_W-1:0] win_moe_o
);
  always_comb begin
    win_act_o = ACT_NONE;
    win_moe_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i] != ACT_NONE) begin
        win_act_o = act_i[i];
        win_moe_o = src_moe(i);
      end
    end
  end
endmodule

// File: rtl/dbg_state_reg.sv
module dbg_state_reg
  import dbg_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  act_t             win_act_i,
  input  logic [MOE_W-1:0] win_moe_i,
  input  logic             clr_i,
  output logic             enter_q,
  output logic             exc_q,
  output logic             pabt_q,
  output logic             flag_q,
  output logic [MOE_W-1:0] moe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enter_q <= 1'b0;
      exc_q   <= 1'b0;
      pabt_q  <= 1'b0;
      flag_q  <= 1'b0;
      moe_q   <= '0;
    end else if (flag_q) begin
      enter_q <= 1'b0;
      exc_q   <= 1'b0;
      pabt_q  <= 1'b0;
      if (clr_i) flag_q <= 1'b0;
    end else begin
      enter_q <= (win_act_i == ACT_ENTER);
      exc_q   <= (win_act_i == ACT_EXC);
      pabt_q  <= (win_act_i == ACT_PABT);
      if (win_act_i == ACT_ENTER) begin
        flag_q <= 1'b1;
        moe_q  <= win_moe_i;
      end
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_q, exc_q, pabt_q})); // R9
  AST_ENTER_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    enter_q |-> flag_q); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q); // R10
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr_i) |=> !flag_q); // R10
  AST_MOE_STABLE_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act_i != ACT_ENTER) |=> $stable(moe_q)); // R5
endmodule

// File: rtl/dbg_event_arbiter.sv
module dbg_event_arbiter
  import dbg_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_en_i,
  input  logic             dbg_permit_i,
  input  logic [1:0]       dbg_mode_i,
  input  logic             priv_i,
  input  logic             ext_req_i,
  input  logic             halt_cmd_i,
  input  logic             bkpt_insn_i,
  input  logic             brk_hit_i,
  input  logic [1:0]       brk_kind_i,
  input  logic             wpt_hit_i,
  input  logic             vcatch_hit_i,
  input  logic [2:0]       vcatch_kind_i,
  input  logic             state_clr_i,
  output logic             enter_o,
  output logic             dbg_exc_o,
  output logic             pabort_o,
  output logic             in_debug_o,
  output logic [3:0]       entry_method_o
);
  logic [NUM_SRC-1:0] ev_vec;
  logic               en_ok;
  act_t [NUM_SRC-1:0] src_act;
  act_t               win_act;
  logic [MOE_W-1:0]   win_moe;

  always_comb begin
    ev_vec           = '0;
    ev_vec[SRC_EXT]  = ext_req_i;
    ev_vec[SRC_HALT] = halt_cmd_i;
    ev_vec[SRC_BKI]  = bkpt_insn_i;
    ev_vec[SRC_BRK]  = brk_hit_i;
    ev_vec[SRC_WPT]  = wpt_hit_i;
    ev_vec[SRC_VC]   = vcatch_hit_i;
  end

  assign en_ok = dbg_en_i && dbg_permit_i;

  dbg_evt_filter #(.N(NUM_SRC)) u_filter (
    .ev_i      (ev_vec),
    .blocked_i (in_debug_o),
    .en_ok_i   (en_ok),
    .mode_i    (dbg_mode_i),
    .priv_i    (priv_i),
    .bk_i      (brk_kind_i),
    .vk_i      (vcatch_kind_i),
    .act_o     (src_act)
  );

  dbg_evt_prio #(.N(NUM_SRC)) u_prio (
    .act_i     (src_act),
    .win_act_o (win_act),
    .win_moe_o (win_moe)
  );

  dbg_state_reg u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_act_i (win_act),
    .win_moe_i (win_moe),
    .clr_i     (state_clr_i),
    .enter_q   (enter_o),
    .exc_q     (dbg_exc_o),
    .pabt_q    (pabort_o),
    .flag_q    (in_debug_o),
    .moe_q     (entry_method_o)
  );

  AST_DISABLED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en_i |=> (!enter_o && !dbg_exc_o)); // R1
  AST_MON_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode_i == 2'b10 && !ext_req_i && !halt_cmd_i) |=> !enter_o); // R5
  AST_EXC_ONLY_MONITOR: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode_i != 2'b10) |=> !dbg_exc_o); // R5
  AST_MON_ABORT_VC_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode_i == 2'b10 && vcatch_hit_i && vcatch_kind_i inside {3'b011, 3'b100}
     && !ext_req_i && !halt_cmd_i && !bkpt_insn_i && !brk_hit_i && !wpt_hit_i)
    |=> !(enter_o || dbg_exc_o || pabort_o)); // R6
  AST_PABT_ONLY_BKPT: assert property (@(posedge clk) disable iff (!rst_n)
    !bkpt_insn_i |=> !pabort_o); // R8
  AST_NO_ACT_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug_o |=> !(enter_o || dbg_exc_o || pabort_o)); // R10
endmodule

// File: tb/sim_dbg_event_arbiter.sv
module sim_dbg_event_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, permit = 0, priv = 0;
  logic [1:0] mode = 0;
  logic ext = 0, halt = 0, bki = 0, brk = 0, wpt = 0, vc = 0, clr = 0;
  logic [1:0] bk = 0;
  logic [2:0] vk = 0;
  logic enter_o, exc_o, pabt_o, flag_o;
  logic [3:0] moe_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // model state
  logic       m_flag = 0;
  logic [3:0] m_moe = 0;

  // scoreboard queues
  int         q_due[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbg_event_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .dbg_en_i(en), .dbg_permit_i(permit),
    .dbg_mode_i(mode), .priv_i(priv), .ext_req_i(ext), .halt_cmd_i(halt),
    .bkpt_insn_i(bki), .brk_hit_i(brk), .brk_kind_i(bk), .wpt_hit_i(wpt),
    .vcatch_hit_i(vc), .vcatch_kind_i(vk), .state_clr_i(clr),
    .enter_o(enter_o), .dbg_exc_o(exc_o), .pabort_o(pabt_o),
    .in_debug_o(flag_o), .entry_method_o(moe_o)
  );

  function automatic logic [7:0] pack_out(input logic e, x, p, f, input logic [3:0] m);
    return {e, x, p, f, m};
  endfunction

  // monitor: compares once the due cycle has passed
  always @(negedge clk) begin
    if (q_due.size() > 0 && q_due[0] <= cyc) begin
      logic [7:0] exp_v, act_v;
      string t;
      exp_v = q_exp.pop_front();
      t = q_tag.pop_front();
      void'(q_due.pop_front());
      act_v = pack_out(enter_o, exc_o, pabt_o, flag_o, moe_o);
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s: {enter,exc,pabt,flag,moe} actual=%b expected=%b", t, act_v, exp_v);
      end
    end
  end

  // driver: applies one cycle of stimulus and predicts the result
  task automatic ev(input string tag, input logic e_ext = 0, input logic e_halt = 0,
                    input logic e_bki = 0, input logic e_brk = 0, input logic [1:0] e_bk = 0,
                    input logic e_wpt = 0, input logic e_vc = 0, input logic [2:0] e_vk = 0,
                    input logic e_clr = 0);
    logic ok, halting, monitor, x_en, x_ex, x_pa, done;
    logic [3:0] code;
    @(negedge clk);
    ext = e_ext; halt = e_halt; bki = e_bki; brk = e_brk; bk = e_bk;
    wpt = e_wpt; vc = e_vc; vk = e_vk; clr = e_clr;
    x_en = 0; x_ex = 0; x_pa = 0; code = m_moe; done = 0;
    ok = en & permit;
    halting = ok && (mode == 2'b01 || mode == 2'b11);
    monitor = ok && (mode == 2'b10);
    if (m_flag) begin
      if (e_clr) m_flag = 0;
    end else begin
      if (ok && e_ext) begin x_en = 1; code = 4'd4; done = 1; end
      if (!done && ok && e_halt) begin x_en = 1; code = 4'd0; done = 1; end
      if (!done && e_bki) begin
        done = 1;
        if (halting) begin x_en = 1; code = 4'd3; end
        else if (monitor) x_ex = 1;
        else x_pa = 1;
      end
      if (!done && e_brk) begin
        if (halting) begin x_en = 1; code = 4'd1; done = 1; end
        else if (monitor && !(priv && e_bk[1])) begin x_ex = 1; done = 1; end
      end
      if (!done && e_wpt) begin
        if (halting) begin x_en = 1; code = 4'd2; done = 1; end
        else if (monitor) begin x_ex = 1; done = 1; end
      end
      if (!done && e_vc) begin
        if (halting) begin x_en = 1; code = 4'd5; done = 1; end
        else if (monitor && e_vk != 3'd3 && e_vk != 3'd4) begin x_ex = 1; done = 1; end
      end
      if (x_en) begin m_flag = 1; m_moe = code; end
    end
    q_due.push_back(cyc + 1);
    q_exp.push_back(pack_out(x_en, x_ex, x_pa, m_flag, m_moe));
    q_tag.push_back(tag);
  endtask

  task automatic cfg(input logic c_en, input logic c_permit, input logic [1:0] c_mode,
                     input logic c_priv);
    @(negedge clk);
    ext = 0; halt = 0; bki = 0; brk = 0; wpt = 0; vc = 0; clr = 0;
    en = c_en; permit = c_permit; mode = c_mode; priv = c_priv;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R11
    if ({enter_o, exc_o, pabt_o, flag_o, moe_o} !== 8'b0) begin
      errors++;
      $display("FAIL R11 reset: actual=%b expected=%b",
               {enter_o, exc_o, pabt_o, flag_o, moe_o}, 8'b0);
    end
    rst_n = 1;

    // R1: enable low
    cfg(0, 1, 2'b01, 0);
    ev("R1 brk disabled", .e_brk(1));
    ev("R1 bkpt pabt", .e_bki(1));
    ev("R1 ext disabled", .e_ext(1));
    ev("R1 halt disabled", .e_halt(1));
    ev("R1 wpt disabled", .e_wpt(1));

    // R8: no mode / not permitted
    cfg(1, 1, 2'b00, 0);
    ev("R8 brk none", .e_brk(1));
    ev("R8 wpt none", .e_wpt(1));
    ev("R8 vc none", .e_vc(1), .e_vk(3'd1));
    ev("R8 bkpt pabt", .e_bki(1));
    cfg(1, 0, 2'b01, 0);
    ev("R8 brk not permitted", .e_brk(1));
    ev("R8 bkpt not permitted", .e_bki(1));
    ev("R8 ext not permitted", .e_ext(1));

    // R2 and R10
    cfg(1, 1, 2'b00, 0);
    ev("R2 ext mode 00", .e_ext(1));
    ev("R10 blocked while flag", .e_bki(1));
    ev("R10 blocked halt", .e_halt(1));
    ev("R10 clear with event", .e_clr(1), .e_ext(1));
    ev("R10 idle after clear");
    ev("R10 clear when idle", .e_clr(1));

    // R3
    cfg(1, 1, 2'b10, 0);
    ev("R3 halt monitor", .e_halt(1));
    ev("R3 clear", .e_clr(1));

    // R4 halting
    cfg(1, 1, 2'b01, 0);
    ev("R4 brk enter", .e_brk(1), .e_bk(2'b11));
    ev("R4 clear", .e_clr(1));
    ev("R4 wpt enter", .e_wpt(1));
    ev("R4 clear", .e_clr(1));
    ev("R4 bkpt enter", .e_bki(1));
    ev("R4 clear", .e_clr(1));
    ev("R4 vc enter", .e_vc(1), .e_vk(3'd3));
    ev("R4 clear", .e_clr(1));
    cfg(1, 1, 2'b11, 1);
    ev("R4 mode 11 wpt", .e_wpt(1));
    ev("R4 clear", .e_clr(1));
    ev("R3 halt reloads 0000", .e_halt(1));
    ev("R3 clear", .e_clr(1));
    ev("R2 ext mode 11", .e_ext(1));
    ev("R2 clear", .e_clr(1));

    // R5 R6 R7 monitor
    cfg(1, 1, 2'b10, 0);
    ev("R7 user mismatch exc", .e_brk(1), .e_bk(2'b11));
    ev("R7 user unlinked exc", .e_brk(1), .e_bk(2'b10));
    ev("R5 wpt exc", .e_wpt(1));
    ev("R5 bkpt exc", .e_bki(1));
    ev("R5 vc exc", .e_vc(1), .e_vk(3'd0));
    ev("R6 vc pabt dropped", .e_vc(1), .e_vk(3'd3));
    ev("R6 vc dabt dropped", .e_vc(1), .e_vk(3'd4));
    ev("R6 vc other kind", .e_vc(1), .e_vk(3'd6));
    cfg(1, 1, 2'b10, 1);
    ev("R7 priv unlinked dropped", .e_brk(1), .e_bk(2'b10));
    ev("R7 priv mismatch dropped", .e_brk(1), .e_bk(2'b11));
    ev("R7 priv linked exc", .e_brk(1), .e_bk(2'b01));
    ev("R7 priv address exc", .e_brk(1), .e_bk(2'b00));

    // R9 priority
    ev("R9 dropped brk yields wpt", .e_brk(1), .e_bk(2'b10), .e_wpt(1));
    ev("R9 dropped vc alone", .e_vc(1), .e_vk(3'd4), .e_brk(1), .e_bk(2'b11));
    ev("R9 halt over monitor sw", .e_halt(1), .e_bki(1), .e_wpt(1));
    ev("R9 clear", .e_clr(1));
    cfg(1, 1, 2'b01, 0);
    ev("R9 ext over halt and brk", .e_ext(1), .e_halt(1), .e_brk(1));
    ev("R9 clear", .e_clr(1));
    ev("R9 halt over bkpt", .e_halt(1), .e_bki(1));
    ev("R9 clear", .e_clr(1));
    ev("R9 bkpt over wpt vc", .e_bki(1), .e_wpt(1), .e_vc(1));
    ev("R9 clear", .e_clr(1));
    ev("R9 brk over wpt", .e_brk(1), .e_wpt(1), .e_vc(1));
    ev("R9 clear", .e_clr(1));
    ev("R9 wpt over vc", .e_wpt(1), .e_vc(1));
    ev("R9 clear", .e_clr(1));
    cfg(1, 1, 2'b00, 0);
    ev("R9 ext over bkpt pabt", .e_ext(1), .e_bki(1));
    ev("R9 clear", .e_clr(1));
    cfg(0, 1, 2'b11, 0);
    ev("R1 ext+bkpt disabled pabt", .e_ext(1), .e_bki(1));
    ev("R1 idle");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule